// File: doc/BRIEF.md
# Command-Driven Two-Wire EEPROM Byte Engine

This block is a byte-level master for a two-wire serial EEPROM bus, driven one primitive at a time by a processor. Software writes a 4-bit code to start a bus START, a STOP, a one-byte transmit, or a one-byte receive. A receive either acknowledges the byte or, for the last byte, leaves the acknowledge bit released. Software then polls the BUSY status bit or waits for the interrupt. A single data register holds the byte to send before a transmit and holds the byte read after a receive. Status bits report an illegal or refused command, the acknowledge returned by the slave, and the acknowledge the master last sent.

The serial clock comes from the system clock through a divider. One bit period is four quarter phases of `QUARTER_CYCLES` system cycles each: two phases with the clock low, then two with it high. Any operation command starts the clock, and it keeps toggling between commands until software issues the no-op code. The clock then halts in its high level. The data line is open drain: `sda_oe` high pulls it low, and `sda_in` reads the wired level.

The sequencer has six states. IDLE takes commands. ALIGN waits for the next falling clock edge. After that edge the state moves to START, STOP, SEND or RECV, depending on the command held. START and STOP each last one bit slot, and SEND and RECV each last nine. Each operation state returns to IDLE on the falling edge that closes its last slot, and BUSY clears on that same edge. Within a slot, the data line is set one quarter after the falling edge. The line is sampled, or moved for START and STOP, at the middle of the high phase.

Top module: `eeprom_byte_master`

## Requirements
- R1: After reset the status byte reads 0x30: ERROR (bit 7) 0, BUSY (bit 6) 0, RX_ACK (bit 5) 1, TX_ACK (bit 4) 1, bits 3:0 read 0. The serial clock rests high, `sda_oe` is 0 and `irq` is 0.
- R2: A write of 1001 (START), 0101 (STOP), 0011 (transmit), 0010 (receive with ACK) or 0110 (receive last, NACK) while BUSY is 0 sets BUSY in the next cycle.
- R3: While running, the serial clock has a period of 4×QUARTER_CYCLES system cycles, low for the first half and high for the second. Any operation command starts it, and it keeps toggling after the command ends. Code 0000 stops it once it reaches its high level, where it then stays.
- R4: START makes the data line fall while the clock is high, and STOP makes it rise while the clock is high. In a transmit or receive, the data line never changes while the clock is high.
- R5: Transmit shifts the data register out MSB first over eight clock pulses. It releases the line for a ninth pulse and sets RX_ACK to 1 if the line is low at mid-high, and to 0 otherwise.
- R6: Receive samples eight bits MSB first at the middle of each high phase. The byte appears in the data register when BUSY falls.
- R7: Code 0010 pulls the line low during the ninth pulse and sets TX_ACK to 1. Code 0110 leaves the line released and sets TX_ACK to 0.
- R8: Any other nonzero code, written while not busy, does nothing and sets ERROR to 1. An accepted legal code, including 0000, clears ERROR.
- R9: A command written while BUSY is 1 is ignored and sets ERROR to 1. The running operation finishes unchanged.
- R10: `irq` is a one-cycle pulse, high exactly in the first cycle BUSY reads 0 after being 1.
- R11: Writes to the data register while BUSY is 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Strobe writing `cmd_code` to the command field |
| cmd_code | input | 4 | Command code |
| data_wr | input | 1 | Strobe writing `data_wdata` to the data register |
| data_wdata | input | BYTE_BITS | Byte to transmit |
| status | output | 8 | {ERROR, BUSY, RX_ACK, TX_ACK, 4'b0} |
| data_rdata | output | BYTE_BITS | Data register contents |
| irq | output | 1 | Completion pulse |
| scl_out | output | 1 | Serial clock |
| sda_oe | output | 1 | 1 pulls the data line low |
| sda_in | input | 1 | Level of the data line |

## Verification
A wrong phase or slot count shows first on `scl_out` or as BUSY falling on the wrong cycle. The bench compares both against its model on every clock, so the mismatch appears within one quarter phase. A wrong shift or sampling point shows up when the operation completes, as a wrong captured byte or a wrong data register value. A wrong acknowledge handling shows up as a wrong ACK level seen on the line or a wrong status bit. Data-line movement under a high clock is watched on every cycle, so a misplaced edge during a byte transfer is reported in the cycle it happens.

// File: rtl/ebm_pkg.sv
package ebm_pkg;

    localparam logic [3:0] CMD_NOP   = 4'b0000;
    localparam logic [3:0] CMD_RXACK = 4'b0010;
    localparam logic [3:0] CMD_TX    = 4'b0011;
    localparam logic [3:0] CMD_STOP  = 4'b0101;
    localparam logic [3:0] CMD_RXNAK = 4'b0110;
    localparam logic [3:0] CMD_START = 4'b1001;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ALIGN,
        ST_START,
        ST_STOP,
        ST_SEND,
        ST_RECV
    } seq_state_t;

    function automatic logic is_op(input logic [3:0] c);
        return (c == CMD_RXACK) || (c == CMD_TX) || (c == CMD_STOP) ||
               (c == CMD_RXNAK) || (c == CMD_START);
    endfunction

endpackage

// File: rtl/ebm_phase_gen.sv
module ebm_phase_gen #(
    parameter int QUARTER_CYCLES = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    output logic [1:0] phase_o,
    output logic       tick_o
);

    localparam int CW = $clog2(QUARTER_CYCLES + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(QUARTER_CYCLES - 1);

    logic [CW-1:0] cnt_q;
    logic [1:0]    phase_q;
    logic          halted;

    assign halted  = !run_i && (phase_q == 2'd3);
    assign tick_o  = !halted && (cnt_q == CNT_LAST);
    assign phase_o = phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            phase_q <= 2'd3;
        end else if (halted) begin
            cnt_q   <= '0;
        end else if (cnt_q == CNT_LAST) begin
            cnt_q   <= '0;
            phase_q <= phase_q + 2'd1;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    // R3
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && phase_q == 2'd3) |=> (phase_q == 2'd3));

    // R3
    phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != $past(phase_q)) |-> (phase_q == $past(phase_q) + 2'd1));

endmodule

// File: rtl/ebm_sequencer.sv
module ebm_sequencer
    import ebm_pkg::*;
#(
    parameter int BYTE_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           phase_i,
    input  logic                 tick_i,
    input  logic                 cmd_wr_i,
    input  logic [3:0]           cmd_i,
    input  logic                 data_wr_i,
    input  logic [BYTE_BITS-1:0] data_i,
    input  logic                 sda_in_i,
    output logic                 run_o,
    output logic                 busy_o,
    output logic                 err_o,
    output logic                 rx_ack_o,
    output logic                 tx_ack_o,
    output logic                 irq_o,
    output logic                 sda_low_o,
    output logic [BYTE_BITS-1:0] data_o
);

    localparam int SW = $clog2(BYTE_BITS + 1);
    localparam logic [SW-1:0] ACK_SLOT = SW'(BYTE_BITS);

    seq_state_t state_q, state_n;

    logic [3:0]           cmd_q;
    logic [SW-1:0]        slot_q;
    logic [BYTE_BITS-1:0] shreg_q;
    logic [BYTE_BITS-1:0] data_q;
    logic                 busy_q, err_q, rx_ack_q, tx_ack_q, irq_q, run_q, sda_low_q;

    logic ev_fall, ev_set, ev_mid;
    logic in_op, finish, accept, ack_mode, data_slot;
    logic [SW-1:0] last_slot;

    assign ev_fall   = tick_i && (phase_i == 2'd3);
    assign ev_set    = tick_i && (phase_i == 2'd0);
    assign ev_mid    = tick_i && (phase_i == 2'd2);
    assign in_op     = (state_q == ST_START) || (state_q == ST_STOP) ||
                       (state_q == ST_SEND)  || (state_q == ST_RECV);
    assign last_slot = ((state_q == ST_SEND) || (state_q == ST_RECV)) ? ACK_SLOT : '0;
    assign finish    = in_op && ev_fall && (slot_q == last_slot);
    assign accept    = cmd_wr_i && !busy_q;
    assign ack_mode  = (cmd_q == CMD_RXACK);
    assign data_slot = (slot_q < ACK_SLOT);

    // next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && is_op(cmd_i)) state_n = ST_ALIGN;
            end
            ST_ALIGN: begin
                if (ev_fall) begin
                    if (cmd_q == CMD_START)     state_n = ST_START;
                    else if (cmd_q == CMD_STOP) state_n = ST_STOP;
                    else if (cmd_q == CMD_TX)   state_n = ST_SEND;
                    else                        state_n = ST_RECV;
                end
            end
            ST_START, ST_STOP, ST_SEND, ST_RECV: begin
                if (finish) state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q     <= CMD_NOP;
            slot_q    <= '0;
            shreg_q   <= '0;
            data_q    <= '0;
            busy_q    <= 1'b0;
            err_q     <= 1'b0;
            rx_ack_q  <= 1'b1;
            tx_ack_q  <= 1'b1;
            irq_q     <= 1'b0;
            run_q     <= 1'b0;
            sda_low_q <= 1'b0;
        end else begin
            irq_q <= finish;
            if (finish) begin
                busy_q <= 1'b0;
                if (state_q == ST_RECV) begin
                    data_q   <= shreg_q;
                    tx_ack_q <= ack_mode;
                end
            end
            if (cmd_wr_i) begin
                if (busy_q) begin
                    err_q <= 1'b1;
                end else if (cmd_i == CMD_NOP) begin
                    err_q <= 1'b0;
                    run_q <= 1'b0;
                end else if (is_op(cmd_i)) begin
                    err_q  <= 1'b0;
                    run_q  <= 1'b1;
                    busy_q <= 1'b1;
                    cmd_q  <= cmd_i;
                end else begin
                    err_q <= 1'b1;
                end
            end
            if (data_wr_i && !busy_q) data_q <= data_i;
            if (state_q == ST_ALIGN && ev_fall) begin
                slot_q  <= '0;
                shreg_q <= data_q;
            end
            if (in_op && ev_fall && !finish) slot_q <= slot_q + 1'b1;
            if (ev_set) begin
                unique case (state_q)
                    ST_START: sda_low_q <= 1'b0;
                    ST_STOP:  sda_low_q <= 1'b1;
                    ST_SEND:  sda_low_q <= data_slot ? !shreg_q[BYTE_BITS-1] : 1'b0;
                    ST_RECV:  sda_low_q <= data_slot ? 1'b0 : ack_mode;
                    default:  sda_low_q <= sda_low_q;
                endcase
            end
            if (ev_mid) begin
                unique case (state_q)
                    ST_START: sda_low_q <= 1'b1;
                    ST_STOP:  sda_low_q <= 1'b0;
                    ST_SEND: begin
                        if (data_slot) shreg_q  <= shreg_q << 1;
                        else           rx_ack_q <= !sda_in_i;
                    end
                    ST_RECV: begin
                        if (data_slot) shreg_q <= {shreg_q[BYTE_BITS-2:0], sda_in_i};
                    end
                    default: shreg_q <= shreg_q;
                endcase
            end
        end
    end

    assign run_o     = run_q;
    assign busy_o    = busy_q;
    assign err_o     = err_q;
    assign rx_ack_o  = rx_ack_q;
    assign tx_ack_o  = tx_ack_q;
    assign irq_o     = irq_q;
    assign sda_low_o = sda_low_q;
    assign data_o    = data_q;

    // R10
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> (!busy_q && $past(busy_q)));

    // R9
    busy_cmd_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr_i && busy_q) |=> err_q);

    // R2
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr_i && !busy_q && is_op(cmd_i)) |=> (busy_q && !err_q));

    // R8
    bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr_i && !busy_q && !is_op(cmd_i) && cmd_i != CMD_NOP) |=> (err_q && !busy_q));

    // R4
    edge_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i[1] && $past(phase_i[1]) && (sda_low_q != $past(sda_low_q)))
        |-> ($past(state_q) == ST_START || $past(state_q) == ST_STOP));

endmodule

// File: rtl/eeprom_byte_master.sv
module eeprom_byte_master #(
    parameter int QUARTER_CYCLES = 64,
    parameter int BYTE_BITS      = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_wr,
    input  logic [3:0]           cmd_code,
    input  logic                 data_wr,
    input  logic [BYTE_BITS-1:0] data_wdata,
    output logic [7:0]           status,
    output logic [BYTE_BITS-1:0] data_rdata,
    output logic                 irq,
    output logic                 scl_out,
    output logic                 sda_oe,
    input  logic                 sda_in
);

    logic [1:0] phase;
    logic       tick, run, busy, err, rx_ack, tx_ack;

    ebm_phase_gen #(
        .QUARTER_CYCLES(QUARTER_CYCLES)
    ) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (run),
        .phase_o (phase),
        .tick_o  (tick)
    );

    ebm_sequencer #(
        .BYTE_BITS(BYTE_BITS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase_i   (phase),
        .tick_i    (tick),
        .cmd_wr_i  (cmd_wr),
        .cmd_i     (cmd_code),
        .data_wr_i (data_wr),
        .data_i    (data_wdata),
        .sda_in_i  (sda_in),
        .run_o     (run),
        .busy_o    (busy),
        .err_o     (err),
        .rx_ack_o  (rx_ack),
        .tx_ack_o  (tx_ack),
        .irq_o     (irq),
        .sda_low_o (sda_oe),
        .data_o    (data_rdata)
    );

    assign scl_out = phase[1];
    assign status  = {err, busy, rx_ack, tx_ack, 4'b0000};

endmodule

// File: tb/eeprom_byte_master_test.sv
module eeprom_byte_master_test;

    localparam int CLK_PERIOD = 10;
    localparam int Q = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_wr = 1'b0;
    logic [3:0] cmd_code = 4'h0;
    logic       data_wr = 1'b0;
    logic [7:0] data_wdata = 8'h00;
    logic [7:0] status;
    logic [7:0] data_rdata;
    logic       irq, scl_out, sda_oe, sda_in;
    logic       slave_low = 1'b0;

    assign sda_in = !(sda_oe || slave_low);

    eeprom_byte_master #(.QUARTER_CYCLES(Q), .BYTE_BITS(8)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_code(cmd_code),
        .data_wr(data_wr), .data_wdata(data_wdata), .status(status),
        .data_rdata(data_rdata), .irq(irq), .scl_out(scl_out),
        .sda_oe(sda_oe), .sda_in(sda_in)
    );

    always #(CLK_PERIOD/2) clk = !clk;

    int total = 0;
    int bad = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int m_cnt, m_ph, m_run, m_busy, m_irq, m_op, m_slot;
    logic [3:0] m_cmd;
    logic [7:0] sl_byte = 8'h00;
    bit         sl_ack = 1'b0;
    logic [7:0] cap_byte;
    bit         ack_seen;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_ph = 3; m_run = 0; m_busy = 0; m_irq = 0; m_op = 0; m_slot = 0;
            m_cmd = 4'h0;
            slave_low <= 1'b0;
        end else begin
            bit adv, tick, fall, mid, busy_before, legal;
            int last;
            adv  = (m_run != 0) || (m_ph != 3);
            tick = adv && (m_cnt == Q - 1);
            fall = tick && (m_ph == 3);
            mid  = tick && (m_ph == 2);
            busy_before = (m_busy != 0);
            last = (m_cmd == 4'h3 || m_cmd == 4'h2 || m_cmd == 4'h6) ? 8 : 0;
            m_irq = 0;
            if (m_op == 2 && mid && m_cmd == 4'h3 && m_slot < 8)
                cap_byte = {cap_byte[6:0], sda_in};
            if (m_op == 2 && mid && (m_cmd == 4'h2 || m_cmd == 4'h6) && m_slot == 8)
                ack_seen = !sda_in;
            if (m_op == 2 && fall) begin
                if (m_slot == last) begin
                    m_busy = 0; m_irq = 1; m_op = 0;
                end else begin
                    m_slot++;
                end
            end else if (m_op == 1 && fall) begin
                m_op = 2; m_slot = 0;
            end
            legal = (cmd_code == 4'h2) || (cmd_code == 4'h3) || (cmd_code == 4'h5) ||
                    (cmd_code == 4'h6) || (cmd_code == 4'h9);
            if (cmd_wr && !busy_before) begin
                if (cmd_code == 4'h0) m_run = 0;
                else if (legal) begin
                    m_busy = 1; m_op = 1; m_cmd = cmd_code; m_run = 1;
                end
            end
            if (tick) begin
                m_ph = (m_ph + 1) % 4; m_cnt = 0;
            end else if (adv) m_cnt++;
            else m_cnt = 0;
            slave_low <= (m_op == 2 && (m_cmd == 4'h2 || m_cmd == 4'h6) && m_slot < 8 &&
                          !sl_byte[7 - m_slot]) ||
                         (m_op == 2 && m_cmd == 4'h3 && m_slot == 8 && sl_ack);
        end
    end

    // per-clock comparison and bus-condition monitor
    int start_cnt = 0;
    int stop_cnt = 0;
    bit prev_scl = 1'b1;
    bit prev_sda = 1'b1;

    always @(negedge clk) begin
        if (rst_n) begin
            chk(scl_out == (m_ph >= 2), "R3 scl", scl_out, (m_ph >= 2));
            chk(status[6] == m_busy[0], "R2 busy", status[6], m_busy);
            chk(irq == m_irq[0], "R10 irq", irq, m_irq);
            if (scl_out && prev_scl && (sda_in != prev_sda)) begin
                if (!sda_in) start_cnt++;
                else         stop_cnt++;
            end
        end
        prev_scl = scl_out;
        prev_sda = sda_in;
    end

    task automatic wr_cmd(input logic [3:0] c);
        @(negedge clk); cmd_wr = 1'b1; cmd_code = c;
        @(negedge clk); cmd_wr = 1'b0;
    endtask

    task automatic wr_data(input logic [7:0] d);
        @(negedge clk); data_wr = 1'b1; data_wdata = d;
        @(negedge clk); data_wr = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000 && status[6]; i++) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int s0, p0;
        bit all_high;
        repeat (3) @(negedge clk);
        // R1 reset values
        chk(status == 8'h30, "R1 status", status, 8'h30);
        chk(scl_out == 1'b1 && sda_oe == 1'b0 && irq == 1'b0, "R1 pins",
            {scl_out, sda_oe, irq}, 3'b100);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        chk(scl_out == 1'b1, "R3 halted after reset", scl_out, 1);

        // START from halted clock, with a command refused while busy
        s0 = start_cnt;
        wr_cmd(4'h9);
        chk(status[6] == 1'b1, "R2 start accepted", status[6], 1);
        wr_cmd(4'h3);
        chk(status[7] == 1'b1, "R9 err on busy write", status[7], 1);
        wait_idle();
        @(negedge clk);
        chk(start_cnt == s0 + 1, "R4 start condition", start_cnt - s0, 1);
        chk(status[7] == 1'b1 && sda_oe == 1'b1, "R9 start unchanged", {status[7], sda_oe}, 2'b11);
        repeat (40) @(negedge clk);
        chk(status[6] == 1'b0, "R9 refused transmit not run", status[6], 0);

        // transmit with ACK, data write during busy
        wr_data(8'hA5);
        sl_ack = 1'b1;
        s0 = start_cnt; p0 = stop_cnt;
        wr_cmd(4'h3);
        chk(status[7] == 1'b0, "R8 legal clears err", status[7], 0);
        wr_data(8'h00);
        wait_idle();
        chk(cap_byte == 8'hA5, "R5 byte on line", cap_byte, 8'hA5);
        chk(status[5] == 1'b1, "R5 rx_ack set", status[5], 1);
        chk(data_rdata == 8'hA5, "R11 busy data write ignored", data_rdata, 8'hA5);
        chk(start_cnt == s0 && stop_cnt == p0, "R4 no edge under high scl", start_cnt - s0 + stop_cnt - p0, 0);

        // transmit without ACK
        wr_data(8'h3C);
        sl_ack = 1'b0;
        wr_cmd(4'h3);
        wait_idle();
        chk(cap_byte == 8'h3C, "R5 second byte", cap_byte, 8'h3C);
        chk(status[5] == 1'b0, "R5 rx_ack clear on nack", status[5], 0);

        // receive with ACK
        sl_byte = 8'hC6;
        s0 = start_cnt; p0 = stop_cnt;
        wr_cmd(4'h2);
        wr_data(8'hFF);
        wait_idle();
        chk(data_rdata == 8'hC6, "R6 received byte", data_rdata, 8'hC6);
        chk(status[4] == 1'b1, "R7 tx_ack after ack", status[4], 1);
        chk(ack_seen == 1'b1, "R7 ack driven low", ack_seen, 1);
        chk(start_cnt == s0 && stop_cnt == p0, "R4 no edge in receive", start_cnt - s0 + stop_cnt - p0, 0);

        // receive last byte, NACK
        sl_byte = 8'h5A;
        wr_cmd(4'h6);
        wait_idle();
        chk(data_rdata == 8'h5A, "R6 last byte", data_rdata, 8'h5A);
        chk(status[4] == 1'b0, "R7 tx_ack after nack", status[4], 0);
        chk(ack_seen == 1'b0, "R7 line released for nack", ack_seen, 0);

        // STOP
        p0 = stop_cnt;
        wr_cmd(4'h5);
        wait_idle();
        @(negedge clk);
        chk(stop_cnt == p0 + 1, "R4 stop condition", stop_cnt - p0, 1);
        chk(sda_oe == 1'b0, "R4 line released after stop", sda_oe, 0);

        // illegal codes
        wr_cmd(4'hF);
        chk(status[7] == 1'b1 && status[6] == 1'b0, "R8 illegal F", status[7:6], 2'b10);
        wr_cmd(4'h0);
        chk(status[7] == 1'b0, "R8 nop clears err", status[7], 0);
        wr_cmd(4'h1);
        chk(status[7] == 1'b1 && status[6] == 1'b0, "R8 illegal 1", status[7:6], 2'b10);
        chk(data_rdata == 8'h5A, "R8 data untouched", data_rdata, 8'h5A);

        // halt: clock was stopped by the nop above, must rest high
        wr_cmd(4'h0);
        repeat (4 * Q * 2) @(negedge clk);
        all_high = 1'b1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (!scl_out) all_high = 1'b0;
        end
        chk(all_high, "R3 clock halted high", all_high, 1);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule